// File: doc/BRIEF.md
# Word-Tagged Synchronizing Scratchpad

A private scratchpad that holds 16 KB as 64-bit words. Every word has one presence tag that marks it full or empty. A producer and a consumer can therefore hand a word from one to the other without a lock. The tag decides whether a synchronizing access goes ahead. A blocked access changes nothing, so the requester can simply issue it again later.

Each request names one word and one operation. The operations are a plain load, a plain store, a draining load, a filling store, a peek load, an update store, and a tag initialization. Exactly one cycle later the block returns three things:

- the word as it stood before the request,
- a success bit,
- the tag as it stands after the request.

The block accepts one request per cycle with no stalls. A request always sees the effect of the request issued in the cycle before it.

Top module: `fe_scratchpad`

## Requirements
- R1: After reset every tag reads empty (0) and `rsp_valid` is low. `rsp_valid` is high exactly one cycle after each cycle with `req_valid` high.
- R2: Plain load (op code 0) always succeeds. It returns the word and leaves the tag unchanged.
- R3: Plain store (op code 1) always succeeds. It writes `req_wdata` and leaves the tag unchanged.
- R4: Draining load (op code 2) on a full word succeeds, returns the word and makes the tag empty. On an empty word it fails and changes neither the word nor the tag.
- R5: Filling store (op code 3) on an empty word succeeds, writes the data and makes the tag full. On a full word it fails and leaves the data and the tag unchanged.
- R6: Peek load (op code 4) on a full word succeeds, returns the word and leaves it full. On an empty word it fails.
- R7: Update store (op code 5) on a full word succeeds, writes the data and leaves it full. On an empty word it fails and does not write.
- R8: Tag initialization (op code 6) always succeeds. It sets the tag to `req_tag_in` whatever the tag was before, and does not alter the data.
- R9: `rsp_data` is the word content before the request, including for stores. `rsp_tag` is the tag after the request. The tag value 1 means full.
- R10: Op code 7 is reserved. It always fails and changes neither the word nor the tag.
- R11: Back-to-back requests to the same word see each other's effects with no bubble. This holds at both ends of the address range (0 and 2047).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (see R2 to R10) |
| req_addr | input | 11 | Word index |
| req_wdata | input | 64 | Store data |
| req_tag_in | input | 1 | Tag value for initialization |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Operation succeeded |
| rsp_data | output | 64 | Word content before the request |
| rsp_tag | output | 1 | Tag after the request (1 = full) |

## Verification
The assertions check on every cycle:

- a response follows each request,
- a draining load on an empty word and a filling store on a full word both fail, and leave the returned tag unchanged,
- plain accesses and reserved codes never move a tag.

Only the bench scenarios can show that data survives failed stores. They also show that read-before-write data comes back on stores, and that chains of producer/consumer hand-offs and back-to-back accesses at the address limits stay consistent with an independent reference model.

// File: rtl/fe_spm_pkg.sv
package fe_spm_pkg;

   typedef enum logic [2:0] {
      OP_LOAD    = 3'd0,
      OP_STORE   = 3'd1,
      OP_DRAIN   = 3'd2,
      OP_FILL    = 3'd3,
      OP_PEEK    = 3'd4,
      OP_UPDATE  = 3'd5,
      OP_TAGSET  = 3'd6,
      OP_RSVD    = 3'd7
   } spm_op_e;

   typedef struct packed {
      logic ok;
      logic wr_data;
      logic wr_tag;
      logic new_tag;
   } spm_act_t;

   localparam logic TAG_EMPTY = 1'b0;
   localparam logic TAG_FULL  = 1'b1;

endpackage

// File: rtl/fe_spm_decide.sv
module fe_spm_decide
   import fe_spm_pkg::*;
(
   input  spm_op_e  op,
   input  logic     tag_now,
   input  logic     tag_in,
   output spm_act_t act
);

   always_comb begin
      act = '{ok: 1'b0, wr_data: 1'b0, wr_tag: 1'b0, new_tag: tag_now};
      unique case (op)
         OP_LOAD: begin
            act.ok = 1'b1;
         end
         OP_STORE: begin
            act.ok      = 1'b1;
            act.wr_data = 1'b1;
         end
         OP_DRAIN: begin
            act.ok      = (tag_now == TAG_FULL);
            act.wr_tag  = act.ok;
            act.new_tag = act.ok ? TAG_EMPTY : tag_now;
         end
         OP_FILL: begin
            act.ok      = (tag_now == TAG_EMPTY);
            act.wr_data = act.ok;
            act.wr_tag  = act.ok;
            act.new_tag = act.ok ? TAG_FULL : tag_now;
         end
         OP_PEEK: begin
            act.ok = (tag_now == TAG_FULL);
         end
         OP_UPDATE: begin
            act.ok      = (tag_now == TAG_FULL);
            act.wr_data = act.ok;
         end
         OP_TAGSET: begin
            act.ok      = 1'b1;
            act.wr_tag  = 1'b1;
            act.new_tag = tag_in;
         end
         default: begin
            act.ok = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/fe_spm_tag_array.sv
module fe_spm_tag_array #(
   parameter int DEPTH = 2048,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_addr,
   output logic          rd_tag,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic          wr_tag
);

   logic [DEPTH-1:0] tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tag_q <= '0;
      else if (wr_en) tag_q[wr_addr] <= wr_tag;
   end

   assign rd_tag = tag_q[rd_addr];

   // R10
   no_write_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> tag_q == $past(tag_q));

endmodule

// File: rtl/fe_spm_data_array.sv
module fe_spm_data_array #(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 2048,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (rd_en) rdata <= mem[addr];
      if (wr_en) mem[addr] <= wdata;
   end

endmodule

// File: rtl/fe_scratchpad.sv
module fe_scratchpad
   import fe_spm_pkg::*;
#(
   parameter int CAPACITY_BYTES = 16384,
   parameter int DATA_W         = 64,
   localparam int DEPTH         = CAPACITY_BYTES / (DATA_W / 8),
   localparam int AW            = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [AW-1:0]     req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_tag_in,
   output logic              rsp_valid,
   output logic              rsp_ok,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_tag
);

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("fe_scratchpad: DATA_W must be a whole number of bytes");
   end
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("fe_scratchpad: word count must be a power of two");
   end
   if (DEPTH * (DATA_W / 8) != CAPACITY_BYTES) begin : g_bad_cap
      $error("fe_scratchpad: capacity must divide evenly into words");
   end

   spm_op_e  op_e;
   logic     tag_now;
   spm_act_t act;

   assign op_e = spm_op_e'(req_op);

   fe_spm_tag_array #(.DEPTH(DEPTH)) u_tags (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_addr(req_addr),
      .rd_tag (tag_now),
      .wr_en  (req_valid && act.wr_tag),
      .wr_addr(req_addr),
      .wr_tag (act.new_tag)
   );

   fe_spm_decide u_decide (
      .op     (op_e),
      .tag_now(tag_now),
      .tag_in (req_tag_in),
      .act    (act)
   );

   fe_spm_data_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
      .clk  (clk),
      .rd_en(req_valid),
      .wr_en(req_valid && act.wr_data),
      .addr (req_addr),
      .wdata(req_wdata),
      .rdata(rsp_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_ok    <= 1'b0;
         rsp_tag   <= TAG_EMPTY;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_ok  <= act.ok;
            rsp_tag <= act.wr_tag ? act.new_tag : tag_now;
         end
      end
   end

   // R1
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R1
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R4
   drain_empty_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd2 && !tag_now) |=> (!rsp_ok && !rsp_tag));
   // R4
   drain_full_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd2 && tag_now) |=> (rsp_ok && !rsp_tag));
   // R5
   fill_full_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd3 && tag_now) |=> (!rsp_ok && rsp_tag));
   // R2
   plain_keeps_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op[2:1] == 2'b00) |=> (rsp_ok && rsp_tag == $past(tag_now)));
   // R10
   rsvd_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd7) |=> (!rsp_ok && rsp_tag == $past(tag_now)));

endmodule

// File: tb/fe_scratchpad_bench.sv
module fe_scratchpad_bench;

   localparam int DW    = 64;
   localparam int DEPTH = 2048;
   localparam int AW    = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_tag_in = 1'b0;
   logic          rsp_valid, rsp_ok, rsp_tag;
   logic [DW-1:0] rsp_data;

   always #2.5 clk = ~clk;

   fe_scratchpad u_fe_scratchpad (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_tag_in(req_tag_in),
      .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_data(rsp_data), .rsp_tag(rsp_tag)
   );

   typedef struct {
      logic          ok;
      logic          tag;
      logic [DW-1:0] data;
      bit            known;
      string         req;
   } exp_t;

   exp_t          sb[$];
   logic [DW-1:0] m_data[int];
   bit            m_tag[int];
   int            errors = 0;
   int            checks = 0;
   bit            finished = 0;

   task automatic issue(input logic [2:0] op, input int a, input logic [DW-1:0] wd,
                        input logic ti, input string req);
      exp_t e;
      bit   cur;
      @(negedge clk);
      req_valid  = 1'b1;
      req_op     = op;
      req_addr   = AW'(a);
      req_wdata  = wd;
      req_tag_in = ti;
      cur     = m_tag.exists(a) ? m_tag[a] : 1'b0;
      e.known = m_data.exists(a);
      e.data  = e.known ? m_data[a] : '0;
      e.req   = req;
      e.tag   = cur;
      case (op)
         3'd0: e.ok = 1'b1;
         3'd1: begin e.ok = 1'b1; m_data[a] = wd; end
         3'd2: begin e.ok = cur; if (cur) e.tag = 1'b0; end
         3'd3: begin e.ok = !cur; if (!cur) begin e.tag = 1'b1; m_data[a] = wd; end end
         3'd4: e.ok = cur;
         3'd5: begin e.ok = cur; if (cur) m_data[a] = wd; end
         3'd6: begin e.ok = 1'b1; e.tag = ti; end
         default: e.ok = 1'b0;
      endcase
      m_tag[a] = e.tag;
      sb.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL R1: response with none expected (actual valid=1, expected 0)");
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (rsp_ok !== e.ok || rsp_tag !== e.tag || (e.known && rsp_data !== e.data)) begin
               errors++;
               $display("FAIL %s: actual ok=%0b tag=%0b data=%h expected ok=%0b tag=%0b data=%h",
                        e.req, rsp_ok, rsp_tag, rsp_data, e.ok, e.tag, e.data);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1: reset rsp_valid actual=%0b expected=0", rsp_valid);
      end
      rst_n = 1'b1;
      // R1: all tags empty after reset
      issue(3'd2, 5, '0, 0, "R1 drain after reset");
      issue(3'd4, DEPTH-1, '0, 0, "R1 peek after reset");
      // R3 / R2
      issue(3'd1, 5, 64'hA5A5_0000_1111_2222, 0, "R3 plain store");
      issue(3'd0, 5, '0, 0, "R2 plain load");
      issue(3'd4, 5, '0, 0, "R6 peek on empty");
      issue(3'd5, 5, 64'hDEAD, 0, "R7 update on empty");
      issue(3'd0, 5, '0, 0, "R7 data kept after failed update");
      // R5 / R9
      issue(3'd3, 5, 64'h0BAD_CAFE_0000_0001, 0, "R5 fill empty / R9 old data");
      issue(3'd3, 5, 64'h1234, 0, "R5 fill on full fails");
      issue(3'd0, 5, '0, 0, "R5 data kept after failed fill");
      issue(3'd4, 5, '0, 0, "R6 peek on full");
      issue(3'd5, 5, 64'hC0C0_C0C0_C0C0_C0C0, 0, "R7 update on full");
      issue(3'd2, 5, '0, 0, "R4 drain full");
      issue(3'd2, 5, '0, 0, "R4 drain empty fails");
      issue(3'd0, 5, '0, 0, "R4 data kept after drain");
      // R8
      issue(3'd1, 100, 64'h77, 0, "R3 plain store word 100");
      issue(3'd6, 100, '0, 1, "R8 init to full");
      issue(3'd6, 100, '0, 1, "R8 init full on full");
      issue(3'd2, 100, '0, 0, "R8 drain after init");
      issue(3'd6, 100, '0, 1, "R8 re-init full");
      issue(3'd6, 100, '0, 0, "R8 init to empty");
      issue(3'd3, 100, 64'h99, 0, "R8 fill after init empty");
      // R10
      issue(3'd7, 100, 64'hFFFF, 1, "R10 reserved op");
      issue(3'd0, 100, '0, 0, "R10 data kept");
      idle();
      // R11: boundaries, back-to-back
      issue(3'd3, 0, 64'h1, 0, "R11 fill word 0");
      issue(3'd3, DEPTH-1, 64'h2, 0, "R11 fill top word");
      issue(3'd2, 0, '0, 0, "R11 drain word 0");
      issue(3'd3, 0, 64'h3, 0, "R11 refill word 0");
      issue(3'd2, DEPTH-1, '0, 0, "R11 drain top word");
      issue(3'd2, DEPTH-1, '0, 0, "R11 drain top again");
      issue(3'd1, 0, 64'h4, 0, "R11 plain store on full");
      issue(3'd2, 0, '0, 0, "R11 drain sees plain store");
      // producer/consumer chain
      for (int i = 0; i < 40; i++) begin
         issue(3'd3, 300 + (i % 3), DW'(i * 64'h0101_0101), 0, "R5 chain fill");
         issue(3'd2, 300 + (i % 3), '0, 0, "R4 chain drain");
      end
      idle();
      repeat (3) @(negedge clk);
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R1: missing responses actual=%0d expected=0", sb.size());
      end
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule